// File: doc/BRIEF.md
# Message-Counting Handshake Stage

This stage sits on a message stream and counts every message it accepts. Each accepted message yields one outbound beat that carries the running total after that message. The payload is taken off the inbound channel but never examined, so the stage works for any bundle width. Both channels use valid/ready. A transfer happens on a rising clock edge when valid and ready are both high on that channel.

The outbound side has a single registered slot. The stage is ready for a new message only when that slot is empty, or when the slot's current beat leaves on the same edge. A published count can therefore never be overwritten before the consumer takes it. The consumer applies back-pressure by holding `out_ready` low. While it does, the pending beat stays frozen and the inbound side is refused. When the consumer keeps `out_ready` high, the stage accepts one message per cycle and emits one beat per cycle with no idle gaps.

Reset is synchronous and active high. The count register is `COUNT_W` bits wide, 32 by default, and it wraps without any flag.

Top module: `msg_tally_stage`

## Requirements
- R1: While `rst` is high at a clock edge, the count and the output slot are cleared. After reset is released, `out_valid` is 0 and `in_ready` is 1, and the first published count is 1.
- R2: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1.
- R3: At each edge where `in_valid` and `in_ready` are both 1, the count rises by one. On the same edge, the new count is loaded into `out_count` and `out_valid` is set.
- R4: While `out_valid` is 1 and `out_ready` is 0 at an edge, `out_valid` stays 1 and `out_count` keeps its value into the next cycle.
- R5: At an edge where `out_valid` and `out_ready` are both 1 and no inbound transfer happens, `out_valid` becomes 0.
- R6: While `in_valid` and `out_ready` are both held at 1, `out_valid` stays 1 in every cycle after the first accepted message. Successive beats carry successive counts.
- R7: The contents of `in_payload` have no effect on `out_count`, `out_valid` or `in_ready`.
- R8: The count wraps modulo 2^`COUNT_W`, so the value after 2^`COUNT_W`-1 is 0.
- R9: Every accepted message produces exactly one outbound beat, in acceptance order, and no beat is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream offers a message |
| in_ready | output | 1 | Stage can take a message this cycle |
| in_payload | input | PAYLOAD_W | Message bundle, not inspected |
| out_valid | output | 1 | Output slot holds a count |
| out_ready | input | 1 | Downstream takes the pending count |
| out_count | output | COUNT_W | Running total after the latest accepted message |

## Verification
The embedded properties assume that `rst` is held for at least one edge before the stream starts. They also assume that `in_valid` and `out_ready` are settled before each rising edge, because transfers are judged only on the values present at that edge. Beyond that, the properties place no rule on the upstream or downstream side: a producer may drop `in_valid` without a transfer, and a consumer may stall for any length of time. The stimulus changes its inputs only just after rising edges. It mixes long stalls, single-beat drains, saturated streaming and random valid/ready patterns with random payloads. A narrowed count width makes the wrap reachable within the run.

// File: rtl/tally_pkg.sv
package tally_pkg;
  localparam int unsigned DEF_PAYLOAD_W = 64;
  localparam int unsigned DEF_COUNT_W   = 32;

  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_FULL  = 1'b1
  } slot_state_e;
endpackage

// File: rtl/tally_admit.sv
module tally_admit (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic slot_full,
  input  logic out_ready,
  output logic in_ready,
  output logic fire
);
  // Take a message only if the slot is free or drains on this edge.
  always_comb begin
    in_ready = !slot_full || out_ready;
    fire     = in_valid && in_ready;
  end

  // R2
  refuse_only_when_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (slot_full && !out_ready));

  // R3
  fire_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> in_valid);
endmodule

// File: rtl/tally_counter.sv
module tally_counter #(
  parameter int unsigned COUNT_W = tally_pkg::DEF_COUNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  output logic [COUNT_W-1:0] count_q,
  output logic [COUNT_W-1:0] count_inc
);
  localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

  logic [COUNT_W-1:0] count_d;

  always_comb begin
    count_inc = count_q + ONE;
    count_d   = fire ? count_inc : count_q;
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_d;
  end

  // R3 R8
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> count_q == COUNT_W'($past(count_q) + ONE));

  // R3
  count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(count_q));

  // R1
  count_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> count_q == '0);
endmodule

// File: rtl/tally_slot.sv
module tally_slot #(
  parameter int unsigned COUNT_W = tally_pkg::DEF_COUNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [COUNT_W-1:0] load_val,
  input  logic               out_ready,
  output logic               slot_full,
  output logic [COUNT_W-1:0] out_data
);
  import tally_pkg::*;

  slot_state_e        state_q, state_d;
  logic [COUNT_W-1:0] data_d;

  always_comb begin
    state_d = state_q;
    data_d  = out_data;
    if (fire) begin
      state_d = SLOT_FULL;
      data_d  = load_val;
    end else if (out_ready) begin
      state_d = SLOT_EMPTY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SLOT_EMPTY;
      out_data <= '0;
    end else begin
      state_q  <= state_d;
      out_data <= data_d;
    end
  end

  assign slot_full = (state_q == SLOT_FULL);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_full && !out_ready) |=> (slot_full && $stable(out_data)));

  // R5
  drain_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_full && out_ready && !fire) |=> !slot_full);

  // R3
  load_publish_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> (slot_full && out_data == $past(load_val)));

  // R1
  slot_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!slot_full && out_data == '0));
endmodule

// File: rtl/msg_tally_stage.sv
module msg_tally_stage #(
  parameter int unsigned PAYLOAD_W = tally_pkg::DEF_PAYLOAD_W,
  parameter int unsigned COUNT_W   = tally_pkg::DEF_COUNT_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PAYLOAD_W-1:0] in_payload,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [COUNT_W-1:0]   out_count
);
  logic               fire;
  logic               slot_full;
  logic [COUNT_W-1:0] count_q;
  logic [COUNT_W-1:0] count_inc;

  // The bundle is consumed by the handshake only; its bits go nowhere.
  logic payload_unused;
  assign payload_unused = ^in_payload;

  tally_admit u_admit (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .slot_full (slot_full),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .fire      (fire)
  );

  tally_counter #(.COUNT_W(COUNT_W)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .count_q   (count_q),
    .count_inc (count_inc)
  );

  tally_slot #(.COUNT_W(COUNT_W)) u_slot (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .load_val  (count_inc),
    .out_ready (out_ready),
    .slot_full (slot_full),
    .out_data  (out_count)
  );

  assign out_valid = slot_full;

  // R9
  published_matches_total_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_count == count_q);

  // R6
  streaming_no_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && in_valid) |=> out_valid);
endmodule

// File: tb/msg_tally_stage_tb.sv
`timescale 1ns/1ps
module msg_tally_stage_tb;
  localparam int unsigned PW = 12;
  localparam int unsigned CW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          in_ready;
  logic [PW-1:0] in_payload;
  logic          out_valid;
  logic          out_ready;
  logic [CW-1:0] out_count;

  int            n_checks = 0;
  int            n_fails  = 0;
  bit            done     = 1'b0;
  logic [CW-1:0] exp_q[$];
  logic [CW-1:0] exp_total = '0;
  int            wrap_seen = 0;
  bit            first_beat = 1'b1;
  bit            hold_pending = 1'b0;
  logic [CW-1:0] held_val;

  always #2 clk = ~clk;

  msg_tally_stage #(.PAYLOAD_W(PW), .COUNT_W(CW)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_payload (in_payload),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_count  (out_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  // Driver side of the scoreboard: record expected count for each accepted message.
  always @(negedge clk) begin
    if (!rst && in_valid && in_ready) begin
      exp_total = exp_total + 1'b1;
      exp_q.push_back(exp_total);
    end
  end

  // Monitor: pop and compare each outbound beat (R3, R7, R8, R9).
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected beat", int'(out_count), -1);
      end else begin
        logic [CW-1:0] e;
        e = exp_q.pop_front();
        if (first_beat) begin
          check(out_count == 1, "R1 first count", int'(out_count), 1);
          first_beat = 1'b0;
        end
        check(out_count == e, "R9 R3 R7 beat value", int'(out_count), int'(e));
        if (e == '0) wrap_seen++;
      end
    end
  end

  // Stall stability (R4) and ready rule (R2).
  always @(negedge clk) begin
    if (rst) begin
      hold_pending = 1'b0;
    end else begin
      if (hold_pending) begin
        check(out_valid == 1'b1, "R4 valid held", int'(out_valid), 1);
        check(out_count == held_val, "R4 data held", int'(out_count), int'(held_val));
      end
      hold_pending = out_valid && !out_ready;
      held_val     = out_count;
      check(in_ready == (!out_valid || out_ready), "R2 ready rule",
            int'(in_ready), int'(!out_valid || out_ready));
    end
  end

  task automatic step(input bit v, input bit r);
    @(posedge clk);
    #1;
    in_valid   = v;
    out_ready  = r;
    in_payload = PW'($urandom);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_payload = '1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);

    // Single message, then a long stall.
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    repeat (4) step(1'b0, 1'b0);
    @(negedge clk);
    check(out_valid == 1'b1, "R3 valid set after accept", int'(out_valid), 1);
    check(in_ready == 1'b0, "R2 refused while stalled", int'(in_ready), 0);
    // Offer a message while stalled: must not be taken.
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    @(negedge clk);
    check(out_valid == 1'b0, "R5 slot cleared after drain", int'(out_valid), 0);
    check(exp_q.size() == 0, "R9 queue empty after drain", exp_q.size(), 0);

    // Saturated streaming (R6).
    step(1'b1, 1'b1);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1 in_payload = PW'($urandom);
      @(negedge clk);
      check(out_valid == 1'b1, "R6 no idle beat", int'(out_valid), 1);
    end
    step(1'b0, 1'b1);
    repeat (2) step(1'b0, 1'b1);

    // Random traffic with random payloads, long enough to wrap (R7, R8).
    for (int i = 0; i < 1500; i++) begin
      step(($urandom % 4) != 0, ($urandom % 3) != 0);
    end

    // Drain.
    repeat (4) step(1'b0, 1'b1);
    @(negedge clk);
    check(exp_q.size() == 0, "R9 all beats delivered", exp_q.size(), 0);
    check(out_valid == 1'b0, "R5 idle at end", int'(out_valid), 0);
    check(wrap_seen > 0, "R8 wrap observed", wrap_seen, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule